// File: doc/BRIEF.md
# Snapshot Timestamp Capture Registers

This block keeps a free-running 64-bit count of elapsed nanoseconds and exposes a frozen copy of it over a 32-bit register bus. The count is derived from the core clock. A prescaler divides the clock, and every prescaler period the count is raised by the clock period in nanoseconds times the division ratio. The count therefore reads in nanoseconds for any integer clock period.

Software takes a timestamp in two steps. First it writes any value to the trigger offset, which copies the live count into a 64-bit snapshot register. It then reads the two 32-bit halves of that snapshot. The halves cannot tear, because the snapshot stays fixed until the next trigger write. The first trigger after reset stores zero rather than the count, so the first timestamp a profiler reads is its time origin.

All offsets are byte addresses placed one dword apart. They are formed by shifting a dword index left by two: low half at 0x13090, high half at 0x13094, trigger at 0x13098.

Top module: `snap_timer`

## Requirements
- R1: After reset the live count is zero, `rd_data` is zero, and the snapshot holds the parameter `SNAP_RESET`, so reads of the two halves return its two 32-bit halves.
- R2: The live count starts at zero. It rises by `CLK_NS*PRESCALE` at the end of every `PRESCALE`-th clock cycle after reset and holds its value in between.
- R3: A write with any data to byte offset 0x13098 is a capture. The first capture after a reset stores zero in the snapshot.
- R4: Every later capture stores the live count as it stood in the cycle of the write.
- R5: A read of byte offset 0x13090 puts snapshot bits 31:0 on `rd_data` one cycle after the read cycle.
- R6: A read of byte offset 0x13094 puts snapshot bits 63:32 on `rd_data` one cycle after the read cycle.
- R7: Writes to any offset other than 0x13098, including the two read offsets and unaligned neighbours, leave the snapshot and the first-capture state unchanged.
- R8: A read of any offset other than 0x13090 or 0x13094 returns zero. In a cycle after one with no read, `rd_data` is zero.
- R9: Reads never change the snapshot. Repeated reads return the same value until the next capture, and a read issued in the cycle after a capture returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data (ignored by the capture) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |

## Verification
A capture changes the snapshot at the clock edge that samples the trigger write. A read result appears on `rd_data` at the edge after the read cycle. The bench drives each access half a cycle before an edge and compares `rd_data` at the following falling edge, one edge after the read. Its reference count and snapshot advance on the same edges the requirements name, so every expected value is taken from the state just before the edge that acts on it. The captures sweep gaps of zero to many cycles against the prescaler phase, so every phase of the division is captured.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;
    localparam int SNAP_W = 64;
    localparam int HALF_W = 32;
    localparam int unsigned BASE_DW = 32'h4C24;

    typedef logic [SNAP_W-1:0] snap_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } rsel_e;

    typedef struct packed {
        logic  first_done;
        snap_t snap;
    } cap_state_t;

    typedef struct packed {
        half_t rdata;
    } rd_state_t;
endpackage

// File: rtl/snap_ns_counter.sv
module snap_ns_counter
    import snap_timer_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int PRESCALE = 1
) (
    input  logic  clk,
    input  logic  rst,
    output snap_t cnt_o
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int STEP  = CLK_NS * PRESCALE;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        snap_t            cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       tick;

    generate
        if (PRESCALE == 1) begin : g_nodiv
            assign tick = ~|state_q.pre;
        end else begin : g_div
            assign tick = (state_q.pre == PRE_W'(PRESCALE - 1));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (tick) begin
            state_d.pre = '0;
            state_d.cnt = state_q.cnt + SNAP_W'(STEP);
        end else begin
            state_d.pre = state_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign cnt_o = state_q.cnt;

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> state_q.cnt == $past(state_q.cnt) + SNAP_W'(STEP));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state_q.cnt));
endmodule

// File: rtl/snap_capture.sv
module snap_capture
    import snap_timer_pkg::*;
#(
    parameter snap_t SNAP_RESET = 64'h1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_we,
    input  snap_t cnt_i,
    output snap_t snap_o
);
    cap_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cap_we) begin
            state_d.first_done = 1'b1;
            state_d.snap       = state_q.first_done ? cnt_i : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.first_done <= 1'b0;
            state_q.snap       <= SNAP_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign snap_o = state_q.snap;

    assert_first_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_we && !state_q.first_done) |=> snap_o == '0);
    assert_live_R4: assert property (@(posedge clk) disable iff (rst)
        (cap_we && state_q.first_done) |=> snap_o == $past(cnt_i));
    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !cap_we |=> $stable(snap_o) && $stable(state_q.first_done));
endmodule

// File: rtl/snap_read_mux.sv
module snap_read_mux
    import snap_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  rsel_e sel,
    input  snap_t snap_i,
    output half_t rd_data_o
);
    rd_state_t state_d, state_q;

    always_comb begin
        state_d.rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_LO:  state_d.rdata = snap_i[HALF_W-1:0];
                SEL_HI:  state_d.rdata = snap_i[SNAP_W-1:HALF_W];
                default: state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign rd_data_o = state_q.rdata;

    assert_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_LO) |=> rd_data_o == $past(snap_i[HALF_W-1:0]));
    assert_hi_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_HI) |=> rd_data_o == $past(snap_i[SNAP_W-1:HALF_W]));
endmodule

// File: rtl/snap_timer.sv
module snap_timer
    import snap_timer_pkg::*;
#(
    parameter int    ADDR_W     = 20,
    parameter int    CLK_NS     = 10,
    parameter int    PRESCALE   = 1,
    parameter snap_t SNAP_RESET = 64'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data
);
    localparam logic [ADDR_W-1:0] LO_OFS   = ADDR_W'(BASE_DW << 2);
    localparam logic [ADDR_W-1:0] HI_OFS   = ADDR_W'((BASE_DW + 1) << 2);
    localparam logic [ADDR_W-1:0] TRIG_OFS = ADDR_W'((BASE_DW + 2) << 2);

    snap_t cnt;
    snap_t snap;
    logic  cap_we;
    rsel_e sel;
    logic  unused_wdata;

    assign unused_wdata = ^wr_data;
    assign cap_we       = wr_en && (addr == TRIG_OFS);

    always_comb begin
        sel = SEL_NONE;
        if (addr == LO_OFS)      sel = SEL_LO;
        else if (addr == HI_OFS) sel = SEL_HI;
    end

    snap_ns_counter #(.CLK_NS(CLK_NS), .PRESCALE(PRESCALE)) i_cnt (
        .clk(clk), .rst(rst), .cnt_o(cnt)
    );

    snap_capture #(.SNAP_RESET(SNAP_RESET)) i_cap (
        .clk(clk), .rst(rst), .cap_we(cap_we), .cnt_i(cnt), .snap_o(snap)
    );

    snap_read_mux i_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .snap_i(snap),
        .rd_data_o(rd_data)
    );

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || (addr != LO_OFS && addr != HI_OFS)) |=> rd_data == '0);
    assert_other_write_R7: assert property (@(posedge clk) disable iff (rst)
        (addr != TRIG_OFS) |=> $stable(snap));
endmodule

// File: tb/test_snap_timer.sv
module test_snap_timer;
    localparam int ADDR_W = 20;
    localparam int CLK_NS = 7;
    localparam int PRESC  = 3;
    localparam logic [63:0] RSTV = 64'h1234_5678_9ABC_DEF0;
    localparam logic [ADDR_W-1:0] A_LO = 20'h13090;
    localparam logic [ADDR_W-1:0] A_HI = 20'h13094;
    localparam logic [ADDR_W-1:0] A_TR = 20'h13098;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [63:0] m_cnt, m_snap;
    int          m_pre;
    logic        m_first;

    always #5 clk = ~clk;

    snap_timer #(.ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .PRESCALE(PRESC),
                 .SNAP_RESET(RSTV)) i_snap_timer (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    // Reference model built from R2, R3, R4, R7
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_cnt <= '0; m_pre <= 0; m_first <= 1'b0; m_snap <= RSTV;
        end else begin
            if (m_pre == PRESC - 1) begin
                m_pre <= 0; m_cnt <= m_cnt + 64'(CLK_NS * PRESC);
            end else begin
                m_pre <= m_pre + 1;
            end
            if (wr_en && addr == A_TR) begin
                m_first <= 1'b1;
                m_snap  <= m_first ? m_cnt : 64'd0;
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string req);
        logic [31:0] exp;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp = (a == A_LO) ? m_snap[31:0] : (a == A_HI) ? m_snap[63:32] : 32'd0;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
        check(rd_data, exp, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1: reset state
        check(rd_data, 32'd0, "R1 idle data");
        rd(A_LO, "R1 reset low");
        rd(A_HI, "R1 reset high");
        // R7: writes elsewhere are ignored
        wr(A_LO, 32'hFFFF_FFFF);
        wr(A_HI, 32'h1);
        wr(20'h13099, 32'h5);
        wr(20'h1309C, 32'h5);
        wr(20'h03098, 32'h5);
        rd(A_LO, "R7 low after stray writes");
        rd(A_HI, "R7 high after stray writes");
        // R3: first capture is zero
        idle(5);
        wr(A_TR, 32'hA5A5_0000);
        rd(A_LO, "R3 first low");
        check(rd_data, 32'd0, "R3 first low zero");
        rd(A_HI, "R3 first high");
        // R2/R4/R5/R6: sweep gaps across prescaler phases
        for (int g = 0; g < 24; g++) begin
            idle(g);
            wr(A_TR, 32'(g));
            rd(A_LO, "R4 R5 low");
            rd(A_HI, "R4 R6 high");
        end
        // R9: repeated reads stable, back-to-back read after capture
        for (int k = 0; k < 4; k++) rd(A_LO, "R9 repeat low");
        @(negedge clk); addr = A_TR; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; addr = A_LO; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; addr = '0;
        check(rd_data, m_snap[31:0], "R9 read after capture");
        // R8: unmapped reads and idle bus
        rd(A_TR, "R8 trigger read");
        rd(20'h13091, "R8 unaligned");
        rd(20'h1308C, "R8 below");
        rd(20'h00000, "R8 zero");
        idle(2);
        check(rd_data, 32'd0, "R8 idle");
        // R7: stray writes after captures
        wr(A_HI, 32'h0);
        rd(A_LO, "R7 late stray");
        // R2: long run then capture
        idle(1000);
        wr(A_TR, 32'h0);
        rd(A_LO, "R2 long low");
        rd(A_HI, "R2 long high");
        // R3: reset re-arms the zero first capture
        do_reset();
        rd(A_LO, "R1 re-reset low");
        idle(7);
        wr(A_TR, 32'h0);
        rd(A_LO, "R3 rearm low");
        check(rd_data, 32'd0, "R3 rearm zero");
        idle(4);
        wr(A_TR, 32'h0);
        rd(A_LO, "R4 after rearm");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule